// File: doc/BRIEF.md
# Temporal shielding bus encoder

This block drives a narrow on-chip bus of three wires and carries four data bits on it using time rather than extra wires. Each accepted 4-bit item becomes an ordered pair of 3-bit code words. The bus shows the first word on one cycle and the second word on the next. A fixed code table maps data to pairs. No word in the table is 000, and the two words of a pair never make neighbouring lines move in opposite directions.

Before each word is placed on the bus, a crosstalk check compares it with the value the bus holds now. The check has a middle-line unit and an edge-line unit and runs in the same cycle as the table lookup. If either unit flags the step, the bus is first driven to the all-zero shielding vector for one cycle and the pending word follows on the next cycle. A step into 000 has only falling lines and a step out of it has only rising lines, so one shielding cycle is always enough. A receiver can discard every 000 it sees, because data never uses that value.

Data enters through a valid/ready handshake. The bus output is a register.

Top module: `tsb_encoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bus_out` is 000 and `in_ready` is 1.
- R2: Data `d` accepted at a clock edge with no shielding puts the first word of pair `d` on `bus_out` at that same edge and the second word at the next edge. The pairs are built by listing all (first, second) 3-bit words with both nonzero, in ascending order of first and then second. Pairs in which some two neighbouring lines switch in opposite directions are skipped. Pair `d` is the d-th pair that remains, counting from 0. The bit value of line i is bit i of `bus_out`.
- R3: Outside the shielding cycles, `bus_out` only ever shows nonzero code words, so 000 after reset always marks a shielding cycle.
- R4: If the next word would make line 1 switch opposite to both line 0 and line 2, relative to the current `bus_out`, then `bus_out` becomes 000 for one cycle before that word.
- R5: If the next word would make line 0 or line 2 switch opposite to line 1, relative to the current `bus_out`, then `bus_out` becomes 000 for one cycle before that word.
- R6: A shielding cycle lasts exactly one cycle. The word that was held back appears on the next cycle, so a nonzero-to-000 step is always followed by a nonzero value.
- R7: `in_ready` is 0 while a shielding cycle or a second word is still pending, and 1 otherwise. While `in_ready` is 0, `in_valid` and `in_data` have no effect on `bus_out`.
- R8: While `in_ready` is 1 and `in_valid` is 0, `bus_out` holds its value.
- R9: No two consecutive `bus_out` values have neighbouring lines that switch in opposite directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input item is offered |
| in_ready | output | 1 | The block can take an item this cycle |
| in_data | input | 4 | Data item to send |
| bus_out | output | 3 | Registered bus lines |

## Verification
The acceptance of a new item and the shielding decision on its first word happen in the same cycle. The check runs against the last word of the previous item, which is still on the bus at that moment. The bench provokes this by sending an item that ends on 101 followed by one whose first word is 010, which triggers the middle-line unit. It also sends items that end on 001 or 011 followed by first words 010 or 100, which trigger only the edge-line unit. Finally it sweeps every ordered pair of data values. A behavioural reference model built from queues predicts each cycle whether 000 comes before the delayed word and when `in_ready` rises again. The bench compares these predictions with the outputs on every clock.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SHIELD1 = 2'd1,
      ST_SEND2   = 2'd2,
      ST_SHIELD2 = 2'd3
   } tsb_state_e;

endpackage

// File: rtl/tsb_code_map.sv
module tsb_code_map #(
   parameter int DATA_W = 4,
   parameter int LINE_W = 3
) (
   input  logic [DATA_W-1:0] data,
   output logic [LINE_W-1:0] first_w,
   output logic [LINE_W-1:0] second_w
);

   localparam int N_ITEMS = 1 << DATA_W;
   localparam int N_WORDS = 1 << LINE_W;
   localparam int PAIR_W  = 2 * LINE_W;

   // true when no two neighbouring lines move in opposite directions
   function automatic bit clean_pair(input logic [LINE_W-1:0] a,
                                     input logic [LINE_W-1:0] b);
      for (int i = 0; i < LINE_W - 1; i++) begin
         if ((!a[i] && b[i] && a[i+1] && !b[i+1]) ||
             (a[i] && !b[i] && !a[i+1] && b[i+1]))
            return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic int count_valid();
      int n;
      n = 0;
      for (int a = 1; a < N_WORDS; a++)
         for (int b = 1; b < N_WORDS; b++)
            if (clean_pair(LINE_W'(a), LINE_W'(b)))
               n++;
      return n;
   endfunction

   function automatic logic [PAIR_W-1:0] pick(input int k);
      int n;
      n = 0;
      for (int a = 1; a < N_WORDS; a++)
         for (int b = 1; b < N_WORDS; b++)
            if (clean_pair(LINE_W'(a), LINE_W'(b))) begin
               if (n == k)
                  return {LINE_W'(a), LINE_W'(b)};
               n++;
            end
      return '0;
   endfunction

   if (count_valid() < N_ITEMS) begin : g_short_table
      $error("tsb_code_map: too few clean nonzero pairs for DATA_W");
   end

   logic [PAIR_W-1:0] tab [N_ITEMS];

   for (genvar g = 0; g < N_ITEMS; g++) begin : g_tab
      assign tab[g] = pick(g);
   end

   assign {first_w, second_w} = tab[data];

endmodule

// File: rtl/tsb_mid_unit.sv
module tsb_mid_unit #(
   parameter int LINE_W = 3
) (
   input  logic [LINE_W-1:0] cur,
   input  logic [LINE_W-1:0] nxt,
   output logic              flag
);

   localparam int N_INNER = LINE_W - 2;

   logic [LINE_W-1:0]  rise, fall;
   logic [N_INNER-1:0] hit;

   assign rise = ~cur & nxt;
   assign fall = cur & ~nxt;

   for (genvar g = 1; g <= N_INNER; g++) begin : g_inner
      assign hit[g-1] = (rise[g] & fall[g-1] & fall[g+1]) |
                        (fall[g] & rise[g-1] & rise[g+1]);
   end

   assign flag = |hit;

endmodule

// File: rtl/tsb_edge_unit.sv
module tsb_edge_unit #(
   parameter int LINE_W = 3
) (
   input  logic [LINE_W-1:0] cur,
   input  logic [LINE_W-1:0] nxt,
   output logic              flag
);

   logic [LINE_W-1:0] rise, fall;
   logic              lo_hit, hi_hit;

   assign rise = ~cur & nxt;
   assign fall = cur & ~nxt;

   assign lo_hit = (rise[0] & fall[1]) | (fall[0] & rise[1]);
   assign hi_hit = (rise[LINE_W-1] & fall[LINE_W-2]) |
                   (fall[LINE_W-1] & rise[LINE_W-2]);

   assign flag = lo_hit | hi_hit;

endmodule

// File: rtl/tsb_xtalk_check.sv
module tsb_xtalk_check #(
   parameter int LINE_W     = 3,
   parameter bit EDGE_CHECK = 1'b1
) (
   input  logic [LINE_W-1:0] cur,
   input  logic [LINE_W-1:0] nxt,
   output logic              flag
);

   logic mid_flag, edge_flag;

   tsb_mid_unit #(.LINE_W(LINE_W)) u_mid (
      .cur  (cur),
      .nxt  (nxt),
      .flag (mid_flag)
   );

   if (EDGE_CHECK) begin : g_edge
      tsb_edge_unit #(.LINE_W(LINE_W)) u_edge (
         .cur  (cur),
         .nxt  (nxt),
         .flag (edge_flag)
      );
   end else begin : g_no_edge
      assign edge_flag = 1'b0;
   end

   assign flag = mid_flag | edge_flag;

endmodule

// File: rtl/tsb_encoder.sv
module tsb_encoder #(
   parameter int DATA_W     = 4,
   parameter int LINE_W     = 3,
   parameter bit EDGE_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic [LINE_W-1:0] bus_out
);

   import tsb_pkg::*;

   if (LINE_W != 3) begin : g_bad_lines
      $error("tsb_encoder: one lane group of exactly three lines is supported");
   end
   if (DATA_W < 1 || DATA_W > 4) begin : g_bad_data
      $error("tsb_encoder: DATA_W must lie in 1..4");
   end

   tsb_state_e        state_q, state_n;
   logic [LINE_W-1:0] bus_q, bus_n;
   logic [LINE_W-1:0] held1_q, held1_n;
   logic [LINE_W-1:0] held2_q, held2_n;
   logic [LINE_W-1:0] map_first, map_second;
   logic [LINE_W-1:0] cand;
   logic              clash;

   tsb_code_map #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_map (
      .data     (in_data),
      .first_w  (map_first),
      .second_w (map_second)
   );

   // word due next: a fresh first word, or the held second word
   assign cand = (state_q == ST_IDLE) ? map_first : held2_q;

   tsb_xtalk_check #(.LINE_W(LINE_W), .EDGE_CHECK(EDGE_CHECK)) u_chk_path (
      .cur  (bus_q),
      .nxt  (cand),
      .flag (clash)
   );

   always_comb begin
      state_n = state_q;
      bus_n   = bus_q;
      held1_n = held1_q;
      held2_n = held2_q;
      unique case (state_q)
         ST_IDLE: begin
            if (in_valid) begin
               held2_n = map_second;
               if (clash) begin
                  bus_n   = '0;
                  held1_n = map_first;
                  state_n = ST_SHIELD1;
               end else begin
                  bus_n   = map_first;
                  state_n = ST_SEND2;
               end
            end
         end
         ST_SHIELD1: begin
            bus_n   = held1_q;
            state_n = ST_SEND2;
         end
         ST_SEND2: begin
            if (clash) begin
               bus_n   = '0;
               state_n = ST_SHIELD2;
            end else begin
               bus_n   = held2_q;
               state_n = ST_IDLE;
            end
         end
         ST_SHIELD2: begin
            bus_n   = held2_q;
            state_n = ST_IDLE;
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bus_q   <= '0;
         held1_q <= '0;
         held2_q <= '0;
      end else begin
         state_q <= state_n;
         bus_q   <= bus_n;
         held1_q <= held1_n;
         held2_q <= held2_n;
      end
   end

   assign in_ready = (state_q == ST_IDLE);
   assign bus_out  = bus_q;

endmodule

// File: rtl/tsb_encoder_chk.sv
module tsb_encoder_chk #(
   parameter int LINE_W     = 3,
   parameter bit EDGE_CHECK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [LINE_W-1:0] bus_out
);

   logic [LINE_W-1:0] prev_q;
   logic [LINE_W-1:0] up, dn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= bus_out;
   end

   assign up = ~prev_q & bus_out;
   assign dn = prev_q & ~bus_out;

   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bus_out == '0 && in_ready));

   a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> $stable(bus_out));

   a_r6_shield_once: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_out == '0 && $past(bus_out) != '0) |=> (bus_out != '0));

   if (EDGE_CHECK) begin : g_strict
      logic adj_opp;
      assign adj_opp = |((up[LINE_W-2:0] & dn[LINE_W-1:1]) |
                         (dn[LINE_W-2:0] & up[LINE_W-1:1]));
      a_r9_no_opposite: assert property (@(posedge clk) disable iff (!rst_n)
         !adj_opp);
   end else begin : g_mid_only
      logic mid_opp;
      assign mid_opp = |((up[LINE_W-2:1] & dn[LINE_W-3:0] & dn[LINE_W-1:2]) |
                         (dn[LINE_W-2:1] & up[LINE_W-3:0] & up[LINE_W-1:2]));
      a_r4_no_mid_opposite: assert property (@(posedge clk) disable iff (!rst_n)
         !mid_opp);
   end

endmodule

bind tsb_encoder tsb_encoder_chk #(.LINE_W(LINE_W), .EDGE_CHECK(EDGE_CHECK)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .bus_out  (bus_out)
);

// File: tb/tsb_encoder_tb.sv
module tsb_encoder_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [3:0] in_data = 4'd0;
   logic       in_ready;
   logic [2:0] bus_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit checking = 1'b0;
   bit done = 1'b0;
   string cur_req = "R1";

   int first_tab [16];
   int second_tab [16];

   int exp_q [$];
   int m_bus = 0;
   bit m_ready = 1'b1;
   int obs_prev = 0;
   int obs_prev2 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tsb_encoder u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .bus_out  (bus_out)
   );

   // a step is safe when no two neighbouring lines move in opposite directions
   function automatic bit ok_step(input int p, input int n);
      for (int i = 0; i < 2; i++) begin
         int di, dj;
         di = ((n >> i) & 1) - ((p >> i) & 1);
         dj = ((n >> (i+1)) & 1) - ((p >> (i+1)) & 1);
         if (di * dj < 0) return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // behavioural reference: a queue of bus values still to appear
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_q.delete();
         m_bus = 0;
         m_ready = 1'b1;
      end else begin
         if (m_ready && in_valid) begin
            int w1, w2;
            w1 = first_tab[in_data];
            w2 = second_tab[in_data];
            if (!ok_step(m_bus, w1)) exp_q.push_back(0);
            exp_q.push_back(w1);
            if (!ok_step(w1, w2)) exp_q.push_back(0);
            exp_q.push_back(w2);
         end
         if (exp_q.size() > 0) m_bus = exp_q.pop_front();
         m_ready = (exp_q.size() == 0);
      end
   end

   always @(negedge clk) begin
      if (checking && rst_n) begin
         check(cur_req, "bus_out", int'(bus_out), m_bus);
         check(cur_req, "in_ready", int'(in_ready), int'(m_ready));
         // R9: every observed step is free of opposite neighbour moves
         check("R9", "safe step", int'(ok_step(obs_prev, int'(bus_out))), 1);
         // R6: a shield after data is followed by data
         if (obs_prev == 0 && obs_prev2 != 0)
            check("R6", "word after shield nonzero", int'(bus_out != 3'd0), 1);
         obs_prev2 = obs_prev;
         obs_prev  = int'(bus_out);
      end
   end

   task automatic push_item(input int d, input bit noisy);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = 4'(d);
      @(negedge clk);
      if (noisy) begin
         while (!in_ready) begin
            in_data = 4'(d ^ 10);
            @(negedge clk);
         end
      end
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      finish_up();
   end

   initial begin
      int idx;
      idx = 0;
      for (int a = 1; a < 8; a++)
         for (int b = 1; b < 8; b++)
            if (idx < 16 && ok_step(a, b)) begin
               first_tab[idx]  = a;
               second_tab[idx] = b;
               idx++;
            end

      repeat (3) @(negedge clk);
      check("R1", "reset bus_out", int'(bus_out), 0);
      check("R1", "reset in_ready", int'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "bus_out after reset", int'(bus_out), 0);
      check("R1", "in_ready after reset", int'(in_ready), 1);
      checking = 1'b1;

      cur_req = "R2";
      push_item(0, 1'b0);
      push_item(9, 1'b0);
      push_item(15, 1'b0);
      push_item(12, 1'b0);

      cur_req = "R4";
      push_item(3, 1'b0);   // leaves 101 on the bus
      push_item(5, 1'b0);   // first word 010: middle line against both
      push_item(3, 1'b0);
      push_item(8, 1'b0);

      cur_req = "R5";
      push_item(0, 1'b0);   // leaves 001
      push_item(5, 1'b0);   // first word 010: edge against middle
      push_item(6, 1'b0);   // leaves 011
      push_item(14, 1'b0);  // first word 100: edge against middle

      cur_req = "R7";
      push_item(3, 1'b1);
      push_item(7, 1'b1);
      push_item(0, 1'b1);
      push_item(14, 1'b1);

      cur_req = "R8";
      repeat (6) @(negedge clk);
      check("R8", "idle bus value", int'(bus_out), m_bus);

      cur_req = "R3";
      for (int p = 0; p < 16; p++)
         for (int q = 0; q < 16; q++) begin
            push_item(p, 1'b0);
            push_item(q, (q % 3) == 0);
         end

      repeat (4) @(negedge clk);
      checking = 1'b0;
      finish_up();
   end

endmodule